// File: doc/BRIEF.md
# Exhaustive-Mode Spiking Neuron Element

This block models one neuron of a synchronous spiking network. It stores a spike count and, each clock cycle (one step), checks a small rule table fixed by parameters. Each rule has an enabling test on the stored count, a consumption amount `c`, a production amount `p` and a delay `d`. The enabled rule with the lowest index is applied exhaustively. With the count written as `k = s*c + r` (`s >= 1`, `0 <= r < c`), the rule removes `s*c` spikes, keeps `r` and emits `s*p` spikes. A forgetting rule clears a stored count that exactly matches its value and emits nothing.

Spike counts arriving on several input lanes are summed and added to what the rule leaves behind. A delayed rule closes the neuron. While it is closed, arriving spikes are dropped, and the emission comes out `d` steps after the rule was used. The stored count saturates at its maximum, and a one-step flag reports that this happened. A network instantiates one element per neuron and wires `spk_out` of each neuron to input lanes of its targets.

Top module: `spike_neuron_pe`

## Requirements
- R1: After reset the stored count is 0, the element is open, emits nothing and the saturation flag is low.
- R2: An applied firing rule with `k = s*c + r` emits `s*p` in the step it is applied (when `d = 0`) and leaves `r` as the base for the next count. Default table, lowest index first: rule 0 forgets exactly 1 spike. Rule 1 fires on exactly 3 (c=3, p=1, d=0). Rule 2 fires when `k mod 4 = 2` and `k >= 2` (c=2, p=1, d=0). Rule 3 fires when `k >= 48` (c=8, p=1, d=2).
- R3: The enabling test uses only the count at the start of the step. A remainder left by the applied rule is not used by any other rule in that step.
- R4: When several rules are enabled, the lowest-index one is applied (count 50 applies rule 2, not rule 3).
- R5: A forgetting rule sets the count to 0 and emits nothing.
- R6: A rule with delay `d >= 1` applied at step t drives `open_o` low and the emission to 0 in steps t to t+d-1. Inputs in those steps are discarded. At step t+d it emits `s*p`, `open_o` is high, and inputs in that step are accepted.
- R7: If any rule is enabled in an open, non-emitting step, one is applied.
- R8: Inputs from all lanes are summed and added to the remainder after consumption. The result appears on `count_o` in the next step.
- R9: When remainder plus inputs exceeds `2^CW - 1`, the count becomes `2^CW - 1` and `sat_o` is high for exactly the next step.
- R10: In an open step with no enabled rule, nothing is emitted and the count only grows by the inputs.
- R11: In the step where a delayed emission leaves, no rule is applied, even if one is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spk_in | input | NIN*IW | Incoming spike counts, one IW-bit lane per synapse |
| spk_out | output | CW+PW | Spikes emitted in the current step |
| open_o | output | 1 | High when the element accepts inputs in the current step |
| count_o | output | CW | Stored spike count at the start of the step |
| sat_o | output | 1 | Count saturated at the previous update |

## Verification
A wrong stored count shows on `count_o` one step later. It also changes which rule applies, so `spk_out` is wrong in the very step that uses the count. A corrupted hold counter or pending amount shows as `open_o` staying low too long or too short, or as a release with the wrong size exactly `d` steps after the delayed rule. Because each step depends on the last, a single wrong update also spreads into all later steps of a long input sweep.

// File: rtl/spike_neuron_pe.sv
module spike_neuron_pe #(
  parameter int CW  = 6,
  parameter int NIN = 3,
  parameter int IW  = 3,
  parameter int NR  = 4,
  parameter int PW  = 3,
  parameter int DW  = 2,
  parameter logic [NR*2-1:0]  R_KIND = {2'd1, 2'd2, 2'd0, 2'd3},
  parameter logic [NR*CW-1:0] R_A    = {6'd48, 6'd4, 6'd3, 6'd1},
  parameter logic [NR*CW-1:0] R_B    = {6'd0, 6'd2, 6'd0, 6'd0},
  parameter logic [NR*CW-1:0] R_C    = {6'd8, 6'd2, 6'd3, 6'd1},
  parameter logic [NR*PW-1:0] R_P    = {3'd1, 3'd1, 3'd1, 3'd0},
  parameter logic [NR*DW-1:0] R_D    = {2'd2, 2'd0, 2'd0, 2'd0}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NIN*IW-1:0]   spk_in,
  output logic [CW+PW-1:0]    spk_out,
  output logic                open_o,
  output logic [CW-1:0]       count_o,
  output logic                sat_o
);
  localparam int EW = CW + PW;
  localparam int SW = IW + $clog2(NIN + 1);
  localparam int TW = ((CW > SW) ? CW : SW) + 1;
  localparam int XW = (NR > 1) ? $clog2(NR) : 1;
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};
  localparam logic [1:0] K_EXACT = 2'd0, K_MIN = 2'd1, K_MOD = 2'd2, K_FORGET = 2'd3;

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q;
  logic          rel_q;
  logic [EW-1:0] pend_q;
  logic          sat_q;

  logic [NR-1:0] en;
  logic [CW-1:0] rem_a  [NR];
  logic [EW-1:0] prod_a [NR];
  logic [DW-1:0] dly_a  [NR];

  for (genvar i = 0; i < NR; i++) begin : g_rule
    localparam logic [1:0]    K = R_KIND[2*i +: 2];
    localparam logic [CW-1:0] A = R_A[CW*i +: CW];
    localparam logic [CW-1:0] B = R_B[CW*i +: CW];
    localparam logic [CW-1:0] C = R_C[CW*i +: CW];
    localparam logic [PW-1:0] P = R_P[PW*i +: PW];
    localparam logic [DW-1:0] D = R_D[DW*i +: DW];
    if (K == K_FORGET) begin : g_forget
      assign en[i]     = (cnt_q == A);
      assign rem_a[i]  = '0;
      assign prod_a[i] = '0;
      assign dly_a[i]  = '0;
    end else begin : g_fire
      logic [CW-1:0] quo;
      assign quo = cnt_q / C;
      if (K == K_EXACT) begin : g_ex
        assign en[i] = (cnt_q == A) && (cnt_q >= C);
      end else if (K == K_MIN) begin : g_mn
        assign en[i] = (cnt_q >= A) && (cnt_q >= C);
      end else begin : g_md
        assign en[i] = (cnt_q >= C) && ((cnt_q % A) == B);
      end
      assign rem_a[i]  = cnt_q % C;
      assign prod_a[i] = EW'(quo) * EW'(P);
      assign dly_a[i]  = D;
    end
  end

  logic [SW-1:0] in_sum;
  always_comb begin
    in_sum = '0;
    for (int j = 0; j < NIN; j++) in_sum = in_sum + SW'(spk_in[j*IW +: IW]);
  end

  logic [XW-1:0] pick;
  logic          hit;
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (en[i]) begin
        hit  = 1'b1;
        pick = XW'(i);
      end
    end
  end

  logic closed_now, release_now, fire, delayed;
  logic [CW-1:0] base;
  logic [TW-1:0] total;
  logic          over;

  assign closed_now  = (hold_q != '0);
  assign release_now = !closed_now && rel_q;
  assign fire        = !closed_now && !rel_q && hit;
  assign delayed     = fire && (dly_a[pick] != '0);
  assign open_o      = !closed_now && !delayed;
  assign spk_out     = release_now ? pend_q : ((fire && !delayed) ? prod_a[pick] : '0);
  assign base        = fire ? rem_a[pick] : cnt_q;
  assign total       = TW'(base) + (open_o ? TW'(in_sum) : '0);
  assign over        = total > TW'(MAXC);
  assign count_o     = cnt_q;
  assign sat_o       = sat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      rel_q  <= 1'b0;
      pend_q <= '0;
      sat_q  <= 1'b0;
    end else begin
      cnt_q  <= closed_now ? cnt_q : (over ? MAXC : total[CW-1:0]);
      hold_q <= closed_now ? hold_q - 1'b1 : (delayed ? dly_a[pick] - 1'b1 : '0);
      rel_q  <= delayed | (rel_q & !release_now);
      pend_q <= delayed ? prod_a[pick] : pend_q;
      sat_q  <= over;
    end
  end
endmodule

module spike_neuron_pe_chk #(
  parameter int CW = 6,
  parameter int EW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [EW-1:0] spk_out,
  input logic          open_o,
  input logic [CW-1:0] count_o,
  input logic          sat_o
);
  a_r6_closed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !open_o |-> spk_out == '0);
  a_r6_closed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_o && $past(!open_o)) |=> $stable(count_o));
  a_r9_flag_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> count_o == {CW{1'b1}});
  a_r11_release_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && $past(!open_o)) |=> count_o >= $past(count_o));
endmodule

bind spike_neuron_pe spike_neuron_pe_chk #(.CW(CW), .EW(CW + PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spk_out(spk_out), .open_o(open_o),
  .count_o(count_o), .sat_o(sat_o));

// File: tb/spike_neuron_pe_bench.sv
module spike_neuron_pe_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] spk_in = '0;
  logic [8:0] spk_out;
  logic       open_o;
  logic [5:0] count_o;
  logic       sat_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spike_neuron_pe u_spike_neuron_pe (
    .clk(clk), .rst_n(rst_n), .spk_in(spk_in), .spk_out(spk_out),
    .open_o(open_o), .count_o(count_o), .sat_o(sat_o));

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int a, int b, int c);
    @(negedge clk);
    spk_in = {3'(c), 3'(b), 3'(a)};
    #1;
  endtask

  task automatic step_chk(string tag, int a, int b, int c, int e_cnt, int e_emit, int e_open);
    drive(a, b, c);
    chk({tag, " count"}, count_o, e_cnt);
    chk({tag, " emit"}, spk_out, e_emit);
    chk({tag, " open"}, open_o, e_open);
  endtask

  int m_cnt, m_hold, m_pend, m_sat;
  bit m_rel;

  task automatic model(int x, output int e_emit, output int e_open);
    int k, rem, tot;
    bit fired;
    k = m_cnt; e_emit = 0; e_open = 1; rem = k; fired = 0;
    if (m_hold > 0) begin
      e_open = 0; m_hold--; m_sat = 0;
      return;
    end
    if (m_rel) begin
      e_emit = m_pend; m_rel = 0;
    end else if (k == 1) begin
      rem = 0;
    end else if (k == 3) begin
      e_emit = 1; rem = 0;
    end else if (k >= 2 && k % 4 == 2) begin
      e_emit = k / 2; rem = 0;
    end else if (k >= 48) begin
      m_pend = k / 8; rem = k % 8; m_hold = 1; m_rel = 1; e_open = 0; fired = 1;
    end
    tot = rem + (fired ? 0 : x);
    m_sat = (tot > 63);
    m_cnt = (tot > 63) ? 63 : tot;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step_chk("R1 reset", 1, 0, 0, 0, 0, 1);
    chk("R1 sat", sat_o, 0);
    step_chk("R8 input added", 0, 0, 0, 1, 0, 1);
    step_chk("R5 forget", 3, 0, 0, 0, 0, 1);
    step_chk("R2 exact rule", 2, 2, 2, 3, 1, 1);
    step_chk("R2 modulo rule s=3", 0, 0, 0, 6, 3, 1);
    step_chk("R8 remainder+sum", 7, 7, 7, 0, 0, 1);
    step_chk("R10 idle 21", 7, 7, 5, 21, 0, 1);
    step_chk("R10 idle 40", 7, 0, 0, 40, 0, 1);
    step_chk("R10 idle 47", 7, 7, 7, 47, 0, 1);
    step_chk("R9 saturate, R6 delayed fire", 7, 7, 7, 63, 0, 0);
    chk("R9 flag high", sat_o, 1);
    step_chk("R6 closed drops input", 5, 0, 0, 7, 0, 0);
    chk("R9 flag pulse only", sat_o, 0);
    step_chk("R6 release", 7, 7, 7, 7, 7, 1);
    step_chk("R6 release input accepted", 7, 7, 7, 28, 0, 1);
    step_chk("R7 delayed fire at 49", 3, 3, 3, 49, 0, 0);
    step_chk("R3 remainder kept", 2, 2, 2, 1, 0, 0);
    step_chk("R6 release s=6", 0, 0, 0, 1, 6, 1);
    step_chk("R11 no rule at release", 0, 0, 0, 1, 0, 1);
    step_chk("R5 forget after release", 7, 7, 7, 0, 0, 1);
    step_chk("R4 build 21", 7, 7, 5, 21, 0, 1);
    step_chk("R4 build 40", 7, 3, 0, 40, 0, 1);
    step_chk("R4 lowest index at 50", 0, 0, 0, 50, 25, 1);
    step_chk("R4 remainder zero", 0, 0, 0, 0, 0, 1);

    @(negedge clk);
    rst_n = 1'b0;
    spk_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_hold = 0; m_pend = 0; m_sat = 0; m_rel = 0;
    for (int i = 0; i < 3000; i++) begin
      int a, b, c, ee, eo, ec, es;
      a = (i * 5 + 3) % 8;
      b = (i * 3) % 8;
      c = (i % 5 == 0) ? 7 : (i % 3);
      if ((i / 64) % 3 == 1) begin a = a & 1; b = 0; end
      ec = m_cnt; es = m_sat;
      model(a + b + c, ee, eo);
      drive(a, b, c);
      chk("R2 sweep count", count_o, ec);
      chk("R7 sweep emit", spk_out, ee);
      chk("R6 sweep open", open_o, eo);
      chk("R9 sweep flag", sat_o, es);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule